// File: doc/BRIEF.md
# Serial Command Latch with Byte-Multiple Frame Check

This block is the serial control front end of an eight-channel output driver. A host lowers the active-low chip select, clocks command bits in on the serial data input, and raises chip select again. The bits that were shifted in are copied to the channel-enable latch, which drives one output channel per bit. The copy happens only when the frame held a nonzero whole multiple of eight serial clocks. Any other frame length is discarded, and the latch keeps what it held before.

While the frame runs, the block also shifts a status byte out, most significant bit first. This status byte is captured when chip select falls. The serial output is enabled only inside a frame, so an external pad can float it while chip select is high. Chip select, serial clock and serial data are all synchronised into the system clock. Their edges are found there, so the system clock must run several times faster than the serial clock.

A small state machine runs each frame. IDLE waits for chip select to fall. On that fall it loads the status byte, clears the bit counter and goes to FRAME. FRAME shifts bits and counts serial clocks until chip select rises, then goes to QUALIFY. QUALIFY writes the latch if the count qualifies and then always goes back to IDLE. A reset request or a low-supply flag clears the latch and forces the machine to IDLE from any state.

Top module: `spi_latch_ctrl`

## Requirements
- R1: While chip select is low, serial data is sampled on each falling serial clock edge and shifted in most significant bit first. The first bit of a byte lands on `drive_out[7]` and the last bit on `drive_out[0]`.
- R2: A frame of exactly eight serial clocks copies its eight bits to `drive_out` within ten system clocks after chip select rises.
- R3: A frame whose serial clock count is not a multiple of eight leaves `drive_out` unchanged.
- R4: A frame of 16, 24 or more (a multiple of eight) serial clocks copies only the last eight bits shifted in.
- R5: A frame with no serial clocks leaves `drive_out` unchanged, and the counter is cleared at the start of every frame.
- R6: `miso_oe` is 1 while a frame is in progress. It is 0 once chip select has been high for four system clocks.
- R7: `miso` shows `status_in`, captured at the chip-select fall. Bit 7 is valid before the first falling serial clock edge, and one bit follows per later rising edge. After eight bits, `miso` carries zeros.
- R8: A one-cycle high on `reset_req` or `low_supply` clears `drive_out` to 0 by the next clock. It also abandons any frame in progress, so that frame's remaining bits have no effect on the latch.
- R9: After `rst_n` is released, `drive_out` is 0 and `miso_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_req | input | 1 | Synchronous forced reset request, active high |
| low_supply | input | 1 | Low-supply flag, active high, same effect as reset_req |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock, idle low |
| mosi | input | 1 | Serial command data in |
| status_in | input | CH_W | Status byte captured at frame start |
| miso | output | 1 | Serial status data out |
| miso_oe | output | 1 | Output enable for the serial data pad |
| drive_out | output | CH_W | Channel-enable latch, one bit per output channel |

## Verification
The bench builds the block with its default parameters: eight channels and a two-stage synchroniser. It drives a serial clock half-period of four system clocks, which keeps every serial edge clear of the synchroniser latency.

With eight channels, the modulo counter wraps at 8. This lets the bench reach several frame lengths: 0, 5, 7, 9 and 12 clocks, which must be rejected, and 8, 16 and 24 clocks, which must be accepted. In the 16-bit frame, the status stream is checked past its eighth bit to confirm that zeros follow.

One frame has a reset request in its middle. This shows that the trailing bits of an abandoned frame cannot reach the latch.

// File: rtl/spi_latch_pkg.sv
package spi_latch_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_FRAME   = 2'd1,
        ST_QUALIFY = 2'd2
    } link_state_t;

endpackage

// File: rtl/spi_edge_sync.sv
// Multi-bit level synchroniser; each bit passes through STAGES flops.
module spi_edge_sync #(
    parameter int              W       = 3,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] level
);

    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= RST_VAL;
        end else begin
            pipe[0] <= din;
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
        end
    end

    assign level = pipe[STAGES-1];

endmodule

// File: rtl/spi_rx_frame.sv
// Command shift register plus modulo bit counter with a sticky nonzero flag.
module spi_rx_frame #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift_en,
    input  logic             din,
    output logic [WIDTH-1:0] data,
    output logic             frame_ok
);

    localparam int             CW   = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0]  LAST = CW'(WIDTH - 1);

    logic [CW-1:0] cnt;
    logic          any_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data    <= '0;
            cnt     <= '0;
            any_bit <= 1'b0;
        end else if (clear) begin
            cnt     <= '0;
            any_bit <= 1'b0;
        end else if (shift_en) begin
            data    <= {data[WIDTH-2:0], din};
            any_bit <= 1'b1;
            cnt     <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign frame_ok = any_bit && (cnt == '0);

endmodule

// File: rtl/spi_tx_status.sv
// Status shifter: loads at frame start, advances on rising serial edges
// once the first falling edge has been seen.
module spi_tx_status #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] status,
    input  logic             arm,
    input  logic             step,
    output logic             dout
);

    logic [WIDTH-1:0] sh;
    logic             armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh    <= '0;
            armed <= 1'b0;
        end else if (load) begin
            sh    <= status;
            armed <= 1'b0;
        end else begin
            if (arm) armed <= 1'b1;
            if (step && armed) sh <= {sh[WIDTH-2:0], 1'b0};
        end
    end

    assign dout = sh[WIDTH-1];

endmodule

// File: rtl/spi_latch_ctrl.sv
module spi_latch_ctrl
    import spi_latch_pkg::*;
#(
    parameter int CH_W        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reset_req,
    input  logic            low_supply,
    input  logic            cs_n,
    input  logic            sclk,
    input  logic            mosi,
    input  logic [CH_W-1:0] status_in,
    output logic            miso,
    output logic            miso_oe,
    output logic [CH_W-1:0] drive_out
);

    localparam int          IN_W    = 3;
    localparam logic [IN_W-1:0] IN_RST = IN_W'(1);

    logic [IN_W-1:0] in_lvl;
    logic            cs_s, sclk_s, mosi_s;
    logic            cs_prev, sclk_prev;
    logic            cs_fall, cs_rise, sclk_fall, sclk_rise;
    logic            force_clr;

    link_state_t     state, state_nx;
    logic            frame_start, in_frame, rx_shift, tx_step, latch_we;
    logic [CH_W-1:0] rx_data;
    logic            frame_ok;

    spi_edge_sync #(
        .W      (IN_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(IN_RST)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({mosi, sclk, cs_n}),
        .level(in_lvl)
    );

    assign cs_s   = in_lvl[0];
    assign sclk_s = in_lvl[1];
    assign mosi_s = in_lvl[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_prev   <= 1'b1;
            sclk_prev <= 1'b0;
        end else begin
            cs_prev   <= cs_s;
            sclk_prev <= sclk_s;
        end
    end

    assign cs_fall   = cs_prev & ~cs_s;
    assign cs_rise   = ~cs_prev & cs_s;
    assign sclk_fall = sclk_prev & ~sclk_s;
    assign sclk_rise = ~sclk_prev & sclk_s;
    assign force_clr = reset_req | low_supply;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         state <= ST_IDLE;
        else if (force_clr) state <= ST_IDLE;
        else                state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (cs_fall) state_nx = ST_FRAME;
            ST_FRAME:   if (cs_rise) state_nx = ST_QUALIFY;
            ST_QUALIFY: state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // State outputs
    always_comb begin
        frame_start = (state == ST_IDLE) && cs_fall && !force_clr;
        in_frame    = (state == ST_FRAME);
        rx_shift    = in_frame && sclk_fall;
        tx_step     = in_frame && sclk_rise;
        latch_we    = (state == ST_QUALIFY) && frame_ok;
        miso_oe     = in_frame;
    end

    spi_rx_frame #(.WIDTH(CH_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (frame_start | force_clr),
        .shift_en(rx_shift),
        .din     (mosi_s),
        .data    (rx_data),
        .frame_ok(frame_ok)
    );

    spi_tx_status #(.WIDTH(CH_W)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (frame_start),
        .status(status_in),
        .arm   (rx_shift),
        .step  (tx_step),
        .dout  (miso)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         drive_out <= '0;
        else if (force_clr) drive_out <= '0;
        else if (latch_we)  drive_out <= rx_data;
    end

endmodule

// File: rtl/spi_latch_ctrl_chk.sv
module spi_latch_ctrl_chk
    import spi_latch_pkg::*;
#(
    parameter int CH_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reset_req,
    input logic            low_supply,
    input logic            cs_n,
    input logic            miso_oe,
    input logic [CH_W-1:0] drive_out,
    input link_state_t     state,
    input logic            frame_start,
    input logic            frame_ok
);

    // R8
    force_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_req || low_supply) |=> (drive_out == '0));

    // R3
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_QUALIFY && !reset_req && !low_supply) |=> $stable(drive_out));

    // R6
    oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) && $past(cs_n, 4))
        |-> !miso_oe);

    // R5
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_ok);

endmodule

bind spi_latch_ctrl spi_latch_ctrl_chk #(.CH_W(CH_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reset_req  (reset_req),
    .low_supply (low_supply),
    .cs_n       (cs_n),
    .miso_oe    (miso_oe),
    .drive_out  (drive_out),
    .state      (state),
    .frame_start(frame_start),
    .frame_ok   (frame_ok)
);

// File: tb/spi_latch_ctrl_bench.sv
module spi_latch_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;

    logic       clk = 1'b0;
    logic       rst_n, reset_req, low_supply, cs_n, sclk, mosi;
    logic [7:0] status_in;
    logic       miso, miso_oe;
    logic [7:0] drive_out;

    int   n_vec = 0;
    int   n_err = 0;
    bit   done  = 0;

    logic [7:0] exp_q [$];
    string      tag_q [$];
    event       chk_ev;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_latch_ctrl u_spi_latch_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reset_req (reset_req),
        .low_supply(low_supply),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .mosi      (mosi),
        .status_in (status_in),
        .miso      (miso),
        .miso_oe   (miso_oe),
        .drive_out (drive_out)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: pops expected latch values and compares against drive_out
    initial begin
        forever begin
            @(chk_ev);
            while (exp_q.size() > 0) begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, drive_out, e);
            end
        end
    end

    task automatic expect_latch(input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        ->chk_ev;
        @(negedge clk);
    endtask

    // Driver: one frame; abort_at >= 0 pulses reset_req before that bit
    task automatic run_frame(input logic [31:0] bits, input int nbits,
                             input logic [7:0] stat, input int abort_at,
                             input logic [7:0] exp, input string t);
        logic [7:0] rx_hi;
        logic [7:0] rx_lo;
        rx_hi = '0;
        rx_lo = '0;
        status_in = stat;
        repeat (4) @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            if (i == abort_at) begin
                reset_req = 1'b1;
                @(negedge clk);
                reset_req = 1'b0;
            end
            mosi = bits[nbits-1-i];
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            if (i == 0 && abort_at < 0) check("R6 oe in frame", {7'd0, miso_oe}, 8'd1);
            if (i < 8) rx_hi = {rx_hi[6:0], miso};
            else if (i < 16) rx_lo = {rx_lo[6:0], miso};
            sclk = 1'b0;
            repeat (HALF) @(negedge clk);
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
        if (abort_at < 0 && nbits >= 8)  check("R7 status", rx_hi, stat);
        if (abort_at < 0 && nbits >= 16) check("R7 zero fill", rx_lo, 8'h00);
        check("R6 oe idle", {7'd0, miso_oe}, 8'd0);
        expect_latch(exp, t);
    endtask

    initial begin
        rst_n = 1'b0; reset_req = 1'b0; low_supply = 1'b0;
        cs_n = 1'b1; sclk = 1'b0; mosi = 1'b0; status_in = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 latch", drive_out, 8'h00);
        check("R9 oe", {7'd0, miso_oe}, 8'd0);

        run_frame(32'hA5,     8,  8'h3C, -1, 8'hA5, "R1 R2 8-bit");
        run_frame(32'h1F,     5,  8'h81, -1, 8'hA5, "R3 5-bit");
        run_frame(32'h12C3,   16, 8'hE7, -1, 8'hC3, "R4 16-bit");
        run_frame(32'h0,      0,  8'h00, -1, 8'hC3, "R5 empty");
        run_frame(32'hFFF,    12, 8'h5A, -1, 8'hC3, "R3 12-bit");
        run_frame(32'h00FF5A, 24, 8'h99, -1, 8'h5A, "R4 24-bit");
        run_frame(32'h7F,     7,  8'h00, -1, 8'h5A, "R3 7-bit");
        run_frame(32'h10F,    9,  8'h42, -1, 8'h5A, "R3 9-bit");

        reset_req = 1'b1; @(negedge clk); reset_req = 1'b0;
        expect_latch(8'h00, "R8 reset_req");
        run_frame(32'h96, 8, 8'h0F, -1, 8'h96, "R2 8-bit");
        low_supply = 1'b1; @(negedge clk); low_supply = 1'b0;
        expect_latch(8'h00, "R8 low_supply");
        run_frame(32'hFF, 8, 8'h00, 4, 8'h00, "R8 abort");
        run_frame(32'h69, 8, 8'hC1, -1, 8'h69, "R1 R2 after abort");

        repeat (4) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

endmodule